// File: doc/BRIEF.md
# Programmable Interval Timer Channel (Rate Generator)

This block is one 16-bit down-counting timer channel. Software programs it through a single byte-wide write port. A select input marks each write as either a control word or a data byte. The control word names the channel, the way the count bytes are accessed, the operating mode and the number format. Data writes then load the count. The channel supports one operating mode, the periodic rate generator, so the count is always binary.

Once a count N is loaded, the output stays high and drops low for exactly one input clock in every N clocks. After each low clock the counter reloads the programmed value without any further action. A typical use is a system tick: the processor writes the control word, then the low byte, then the high byte of the divisor, and the output then pulses at the input clock rate divided by N.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is high and the channel is idle. Data writes have no effect until an accepted control word has been written.
- R2: The control word is decoded as follows. Bits 7:6 select the channel and must be 00. Bits 5:4 select the access: 01 is low byte only, 10 is high byte only, 11 is low byte then high byte, and 00 is not accepted. Bits 3:1 select the mode and must be 010 or 110. Bit 0 selects BCD and must be 0. A word that fails any of these tests is ignored and leaves the output and the running count undisturbed.
- R3: An accepted control word stops the counter, forces the output high, and returns the byte pointer to the low byte, discarding any half-written count.
- R4: In access 11, the first data write is the low byte and the second is the high byte. The count does not start after the low byte alone. The count is taken on the clock edge that captures the high byte, and the first low output appears N-1 clocks after that edge.
- R5: In access 01, a single write loads the low byte and the high byte reads as zero. In access 10, a single write loads the high byte and the low byte reads as zero.
- R6: While counting, the output is low for exactly one clock in every N clocks and high otherwise.
- R7: A programmed count of 0 gives a period of 65536 clocks.
- R8: A count completed while the channel is running does not change the current period. It takes effect at the next reload.
- R9: The count is read as binary, so 0x0012 gives a period of 18. Mode codes 010 and 110 behave identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per clock |
| wr_ctrl | input | 1 | 1: the byte is a control word; 0: the byte is a count byte |
| wr_byte | input | 8 | Write data |
| rate_o | output | 1 | Rate generator output, low for one clock per period |

## Verification
A write is captured on the rising edge where wr_en is high. The output is registered, so it reflects that edge from the next falling edge on. After the edge that completes a count N, the bench expects the first low output at the falling edge N-1 clocks later, and every later low output N clocks after the previous one. An accepted control word makes the output high at the first falling edge after it is captured. A behavioural model in the bench counts the clocks left until the next low output, and its value is compared with the output at every falling edge. Directed checks measure the first-pulse delay and the period in clocks against the same timing.

// File: rtl/pit_pkg.sv
package pit_pkg;

    // Bit positions in the control word.
    localparam int CW_CH_HI   = 7;
    localparam int CW_CH_LO   = 6;
    localparam int CW_ACC_HI  = 5;
    localparam int CW_ACC_LO  = 4;
    localparam int CW_MODE_HI = 3;
    localparam int CW_MODE_LO = 1;
    localparam int CW_BCD     = 0;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_LOHI = 2'b11
    } acc_e;

    typedef struct packed {
        logic accept;
        acc_e acc;
    } ctrl_dec_t;

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int CHAN_ID = 0
) (
    input  logic [BYTE_W-1:0] cw,
    output ctrl_dec_t         dec
);
    localparam int MODE_W = CW_MODE_HI - CW_MODE_LO + 1;
    localparam logic [1:0] MY_CHAN = 2'(CHAN_ID);

    logic [1:0]        chan;
    logic [MODE_W-1:0] mode;
    logic              chan_ok;
    logic              mode_ok;
    logic              fmt_ok;
    acc_e              acc;

    always_comb begin
        chan    = cw[CW_CH_HI:CW_CH_LO];
        acc     = acc_e'(cw[CW_ACC_HI:CW_ACC_LO]);
        mode    = cw[CW_MODE_HI:CW_MODE_LO];
        chan_ok = (chan == MY_CHAN);
        // Rate generator: the top mode bit is a don't-care.
        mode_ok = (mode[MODE_W-2:0] == 2'b10);
        fmt_ok  = !cw[CW_BCD];
        dec.acc    = acc;
        dec.accept = chan_ok && mode_ok && fmt_ok && (acc != ACC_NONE);
    end
endmodule

// File: rtl/pit_load_seq.sv
module pit_load_seq
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  acc_e              ctrl_acc,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val
);
    typedef struct packed {
        logic              cfg;
        acc_e              acc;
        logic              hi_next;
        logic [BYTE_W-1:0] lo_hold;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        load_stb = 1'b0;
        load_val = '0;
        if (ctrl_wr) begin
            s_d.cfg     = 1'b1;
            s_d.acc     = ctrl_acc;
            s_d.hi_next = 1'b0;
        end else if (data_wr && s_q.cfg) begin
            unique case (s_q.acc)
                ACC_LO: begin
                    load_stb = 1'b1;
                    load_val = {{BYTE_W{1'b0}}, data};
                end
                ACC_HI: begin
                    load_stb = 1'b1;
                    load_val = {data, {BYTE_W{1'b0}}};
                end
                ACC_LOHI: begin
                    if (s_q.hi_next) begin
                        load_stb    = 1'b1;
                        load_val    = {data, s_q.lo_hold};
                        s_d.hi_next = 1'b0;
                    end else begin
                        s_d.lo_hold = data;
                        s_d.hi_next = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{cfg: 1'b0, acc: ACC_NONE, hi_next: 1'b0, lo_hold: '0};
        end else begin
            s_q <= s_d;
        end
    end

    // R3: a control word always leaves the pointer on the low byte
    p_ptr_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !s_q.hi_next);

    // R1: once configured, the channel never returns to the unconfigured state
    p_cfg_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cfg |=> s_q.cfg);
endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    output logic             out
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] prog;
        logic             out;
    } ctr_t;

    ctr_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (stop) begin
            c_d.run = 1'b0;
        end else begin
            if (load_stb) begin
                c_d.prog = load_val;
            end
            if (c_q.run) begin
                // A zero count wraps through all ones: 65536 steps.
                if (c_q.cnt == ONE) begin
                    c_d.cnt = c_d.prog;
                end else begin
                    c_d.cnt = c_q.cnt - ONE;
                end
            end else if (load_stb) begin
                c_d.run = 1'b1;
                c_d.cnt = load_val;
            end
        end
        c_d.out = !(c_d.run && (c_d.cnt == ONE));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{run: 1'b0, cnt: '0, prog: '0, out: 1'b1};
        end else begin
            c_q <= c_d;
        end
    end

    assign out = c_q.out;

    // R4: an idle channel starts from the completed count on the next edge
    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !c_q.run && !stop) |=> (c_q.run && c_q.cnt == $past(load_val)));

    // R6: the output can only be low while counting
    p_low_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.out |-> c_q.run);

    // R6: the low phase lasts a single clock for any count other than 1
    p_pulse_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_q.out && !stop && !load_stb && c_q.prog != ONE) |=> c_q.out);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              rate_o
);
    localparam int CNT_W = 2 * BYTE_W;

    ctrl_dec_t        dec;
    logic             ctrl_wr;
    logic             data_wr;
    logic             load_stb;
    logic [CNT_W-1:0] load_val;

    pit_ctrl_decode #(.BYTE_W(BYTE_W), .CHAN_ID(CHAN_ID)) u_dec (
        .cw  (wr_byte),
        .dec (dec)
    );

    assign ctrl_wr = wr_en && wr_ctrl && dec.accept;
    assign data_wr = wr_en && !wr_ctrl;

    pit_load_seq #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .ctrl_acc (dec.acc),
        .data_wr  (data_wr),
        .data     (wr_byte),
        .load_stb (load_stb),
        .load_val (load_val)
    );

    pit_down_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop     (ctrl_wr),
        .load_stb (load_stb),
        .load_val (load_val),
        .out      (rate_o)
    );

    // R3: an accepted control word leaves the output high
    p_ctrl_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> rate_o);

    // R5: a count is only ever completed by a data write
    p_load_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> data_wr);
endmodule

// File: tb/tb_pit_channel.sv
`timescale 1ns/1ps
module tb_pit_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       rate_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    pit_channel dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ctrl (wr_ctrl),
        .wr_byte (wr_byte),
        .rate_o  (rate_o)
    );

    // Reference model: cycles left until the next low output.
    bit m_cfg, m_run, m_hi;
    int m_acc, m_prog, m_left, m_lo;

    function automatic bit cw_ok(input logic [7:0] b);
        return b[7:6] == 2'b00 && b[5:4] != 2'b00 && b[2:1] == 2'b10 && !b[0];
    endfunction

    always @(posedge clk) begin
        bit started;
        bit done;
        int v;
        started = 0;
        done    = 0;
        v       = 0;
        if (!rst_n) begin
            m_cfg = 0; m_run = 0; m_hi = 0; m_acc = 0; m_prog = 0; m_left = 0; m_lo = 0;
        end else begin
            if (wr_en && wr_ctrl && cw_ok(wr_byte)) begin
                m_cfg = 1; m_acc = int'(wr_byte[5:4]); m_hi = 0; m_run = 0;
            end else if (wr_en && !wr_ctrl && m_cfg) begin
                if (m_acc == 1) begin v = int'(wr_byte); done = 1; end
                else if (m_acc == 2) begin v = int'(wr_byte) * 256; done = 1; end
                else if (!m_hi) begin m_lo = int'(wr_byte); m_hi = 1; end
                else begin v = int'(wr_byte) * 256 + m_lo; m_hi = 0; done = 1; end
                if (done) begin
                    m_prog = (v == 0) ? 65536 : v;
                    if (!m_run) begin
                        m_run = 1; m_left = m_prog - 1; started = 1;
                    end
                end
            end
            if (m_run && !started) begin
                if (m_left == 0) m_left = m_prog - 1;
                else m_left = m_left - 1;
            end
        end
    end

    always @(negedge clk) begin
        bit exp_out;
        if (rst_n) begin
            exp_out = !(m_run && m_left == 0);
            checks++;
            if (rate_o !== exp_out) begin
                fails++;
                $display("FAIL R6 per-clock model: rate_o=%0b expected %0b at cycle %0d",
                         rate_o, exp_out, cycles);
            end
        end
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog: run exceeded cycle limit, got %0d expected below %0d",
                     cycles, 190000);
            finish_up();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Each write task starts at a falling edge and returns on the next one.
    task automatic wr(input bit is_ctrl, input logic [7:0] b);
        wr_en = 1'b1; wr_ctrl = is_ctrl; wr_byte = b;
        @(negedge clk);
        wr_en = 1'b0; wr_ctrl = 1'b0;
    endtask

    task automatic to_low(output int n);
        n = 0;
        while (rate_o) begin @(negedge clk); n++; end
    endtask

    task automatic gap(output int n);
        @(negedge clk);
        n = 1;
        while (rate_o) begin @(negedge clk); n++; end
    endtask

    task automatic high_for(input int len, output int lows);
        lows = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (!rate_o) lows++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(rate_o === 1'b1, "R1 output high in reset", int'(rate_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(rate_o === 1'b1, "R1 output high after reset", int'(rate_o), 1);
        wr(0, 8'h05);
        wr(0, 8'h00);
        high_for(20, n);
        check(n == 0, "R1 data ignored before control word", n, 0);

        // R4: low byte then high byte
        wr(1, 8'h34);
        wr(0, 8'h05);
        high_for(10, n);
        check(n == 0, "R4 no start on low byte alone", n, 0);
        wr(0, 8'h00);
        to_low(n);
        check(n == 4, "R4 first low N-1 after load", n, 4);
        @(negedge clk);
        check(rate_o === 1'b1, "R6 low lasts one clock", int'(rate_o), 1);
        to_low(n);
        check(n == 4, "R6 period five", n + 1, 5);

        // R2: ignored control words keep the phase
        wr(1, 8'h74);
        wr(1, 8'h00);
        wr(1, 8'h35);
        wr(1, 8'h30);
        to_low(n);
        check(n == 1, "R2 ignored words leave count running", n, 1);

        // R8: new count while running
        wr(0, 8'h0A);
        wr(0, 8'h00);
        to_low(n);
        check(n == 3, "R8 current period unchanged", n, 3);
        gap(n);
        check(n == 10, "R8 new period after reload", n, 10);

        // R3: stop and pointer reset
        wr(0, 8'h09);
        wr(1, 8'h34);
        high_for(30, n);
        check(n == 0, "R3 counter stopped output high", n, 0);
        wr(0, 8'h07);
        wr(0, 8'h00);
        to_low(n);
        check(n == 6, "R3 pointer back to low byte", n, 6);
        gap(n);
        check(n == 7, "R3 period after restart", n, 7);

        // R9: binary count, mode code 110
        wr(1, 8'h3C);
        wr(0, 8'h12);
        wr(0, 8'h00);
        to_low(n);
        check(n == 17, "R9 binary first low", n, 17);
        gap(n);
        check(n == 18, "R9 binary period", n, 18);

        // R5: single-byte access modes
        wr(1, 8'h14);
        wr(0, 8'h07);
        to_low(n);
        check(n == 6, "R5 low-only first low", n, 6);
        gap(n);
        check(n == 7, "R5 low-only period", n, 7);
        wr(1, 8'h24);
        wr(0, 8'h01);
        to_low(n);
        check(n == 255, "R5 high-only first low", n, 255);

        // R7: zero count
        wr(1, 8'h34);
        wr(0, 8'h00);
        wr(0, 8'h00);
        to_low(n);
        check(n == 65535, "R7 zero means 65536", n, 65535);
        @(negedge clk);
        check(rate_o === 1'b1, "R7 single low clock", int'(rate_o), 1);

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule